// File: doc/BRIEF.md
# Debounced Multi-Line Interrupt Hub

This block watches up to eight input-only lines and turns clean level changes into one shared interrupt. Each line is first brought into the clock domain by a two-stage synchronizer. It then passes through its own debounce filter, which counts millisecond ticks while the synchronized input disagrees with the last accepted level. Once a line holds a new level for its programmed number of milliseconds, the accepted level moves to it. If the new level matches the line's chosen trigger polarity, the line's pending bit is set.

Software programs each line through a small word-wide register port. The settings are the filter length in milliseconds, an interrupt enable, the trigger polarity and a one-shot option. In one-shot mode a line stays locked after its first event until software re-arms it. The interrupt output is a level that stays high while any enabled line has a pending event.

The millisecond timebase comes in as a one-cycle enable pulse, `ms_tick`. The `clk_run` output tells a clock gate when any filter is busy. When every line sits at its accepted level, the counters stay idle and `clk_run` is low.

Top module: `dbnc_irq_hub`

## Requirements
- R1: After reset, all pending bits, accepted levels and lock bits read 0, and `irq` and `clk_run` are low. Each configuration word reads 0, which gives a 1 ms filter, interrupt disabled, trigger level 0 and one-shot off.
- R2: Configuration word fields are as follows: bits 11:0 set the filter length in ms, bit 12 is the interrupt enable, bit 13 is the trigger level and bit 14 is one-shot. A line's synchronized input must differ from its accepted level on N consecutive ticks. The accepted level then takes the input value, and the change is readable in bit n of address 9.
- R3: An excursion that returns to the accepted level before N ticks is discarded. The counter restarts, and neither the level nor the pending bit changes. A pulse with no tick during it has no effect.
- R4: A filter length of 0 acts as 1 ms, and lengths above 4000 act as 4000 ms, so 4000 ms is the longest filter.
- R5: A pending bit is set only when the accepted level changes to the line's trigger level. A change to the other level sets nothing.
- R6: In one-shot mode, an event sets the line's lock bit, read in bit n of address 10. While the lock bit is set, later changes on that line raise no event. Writing 1 to bit n of address 10 clears the lock.
- R7: Pending bits are read in address 8. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. If an event arrives in the same cycle as a clear, the event wins.
- R8: `irq` is high exactly when some line has both its pending bit and its interrupt enable set. It stays high until the condition ends.
- R9: `clk_run` is high exactly when some line's synchronized input differs from its accepted level. Accepted levels change only in cycles where it was high.
- R10: Configuration words at addresses 0 to 7 read back bits 14:0 as written. Bit 15 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| line_in | input | NL | Raw external lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| irq | output | 1 | Shared active-high level interrupt |
| clk_run | output | 1 | Filter busy, clock-gate enable |

## Verification
The assertions check several properties on every cycle after reset:
- the count never reaches the 4000 ms ceiling;
- a pending bit rises only together with a change in accepted level;
- levels move only while `clk_run` was high;
- `irq` never rises without a pending source;
- the state after reset is quiet.

Only the bench scenarios can show the rest, against a behavioural model checked on every clock. That covers filter length, glitch rejection, the 0 and above-4000 clamps, polarity, one-shot lock and re-arm, write-1-to-clear and register readback.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int CNT_W = 12;
  localparam logic [CNT_W-1:0] MS_MAX  = 12'd4000;
  localparam logic [CNT_W-1:0] CNT_ONE = 12'd1;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam logic [AW-1:0] A_PEND = 4'd8;
  localparam logic [AW-1:0] A_LVL  = 4'd9;
  localparam logic [AW-1:0] A_LOCK = 4'd10;

  typedef struct packed {
    logic             once;
    logic             trig;
    logic             ien;
    logic [CNT_W-1:0] ms;
  } line_cfg_t;
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dbi_line.sv
module dbi_line
  import dbi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             sin,
  input  logic             clr,
  input  logic             arm,
  input  line_cfg_t        cfg,
  output logic             level,
  output logic             pend,
  output logic             lock,
  output logic             active,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] lim;
  logic             hit;
  logic             ev;

  // Effective filter length: 0 acts as 1, values above the ceiling are clamped
  always_comb begin
    if (cfg.ms == '0)         lim = CNT_ONE;
    else if (cfg.ms > MS_MAX) lim = MS_MAX;
    else                      lim = cfg.ms;
  end

  assign active = (sin != level);
  assign hit    = active && tick && ((cnt + CNT_ONE) >= lim);
  assign ev     = hit && (sin == cfg.trig) && !(cfg.once && lock);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (!active) begin
      cnt <= '0;
    end else if (tick) begin
      if (hit) begin
        level <= sin;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      lock <= 1'b0;
    end else begin
      if (ev)       pend <= 1'b1;
      else if (clr) pend <= 1'b0;
      if (ev)       lock <= 1'b1;
      else if (arm) lock <= 1'b0;
    end
  end
endmodule

// File: rtl/dbi_regs.sv
module dbi_regs
  import dbi_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic [NL-1:0] pend,
  input  logic [NL-1:0] level,
  input  logic [NL-1:0] lock,
  output line_cfg_t     cfg [NL],
  output logic [NL-1:0] clr,
  output logic [NL-1:0] arm,
  output logic [DW-1:0] rd_data
);
  localparam int CFGW = $bits(line_cfg_t);
  localparam int CPAD = DW - CFGW;
  localparam int VPAD = DW - NL;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NL; i++) begin
      if (rst) begin
        cfg[i] <= '0;
      end else if (wr_en && (wr_addr == AW'(i))) begin
        cfg[i] <= line_cfg_t'(wr_data[CFGW-1:0]);
      end
    end
  end

  assign clr = (wr_en && (wr_addr == A_PEND)) ? wr_data[NL-1:0] : '0;
  assign arm = (wr_en && (wr_addr == A_LOCK)) ? wr_data[NL-1:0] : '0;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NL; i++) begin
      if (rd_addr == AW'(i)) rd_data = {{CPAD{1'b0}}, cfg[i]};
    end
    if (rd_addr == A_PEND) rd_data = {{VPAD{1'b0}}, pend};
    if (rd_addr == A_LVL)  rd_data = {{VPAD{1'b0}}, level};
    if (rd_addr == A_LOCK) rd_data = {{VPAD{1'b0}}, lock};
  end
endmodule

// File: rtl/dbnc_irq_hub.sv
module dbnc_irq_hub
  import dbi_pkg::*;
#(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ms_tick,
  input  logic [NL-1:0] line_in,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  output logic          clk_run
);
  logic [NL-1:0]       sync_vec;
  logic [NL-1:0]       level_vec;
  logic [NL-1:0]       pend_vec;
  logic [NL-1:0]       lock_vec;
  logic [NL-1:0]       act_vec;
  logic [NL-1:0]       ien_vec;
  logic [NL-1:0]       clr_vec;
  logic [NL-1:0]       arm_vec;
  logic [NL*CNT_W-1:0] cnt_flat;
  line_cfg_t           cfg [NL];

  dbi_sync #(.W(NL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (line_in),
    .q   (sync_vec)
  );

  dbi_regs #(.NL(NL)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .pend    (pend_vec),
    .level   (level_vec),
    .lock    (lock_vec),
    .cfg     (cfg),
    .clr     (clr_vec),
    .arm     (arm_vec),
    .rd_data (rd_data)
  );

  for (genvar g = 0; g < NL; g++) begin : g_line
    assign ien_vec[g] = cfg[g].ien;
    dbi_line u_line (
      .clk    (clk),
      .rst    (rst),
      .tick   (ms_tick),
      .sin    (sync_vec[g]),
      .clr    (clr_vec[g]),
      .arm    (arm_vec[g]),
      .cfg    (cfg[g]),
      .level  (level_vec[g]),
      .pend   (pend_vec[g]),
      .lock   (lock_vec[g]),
      .active (act_vec[g]),
      .cnt    (cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  assign irq     = |(pend_vec & ien_vec);
  assign clk_run = |act_vec;
endmodule

// File: rtl/dbnc_irq_chk.sv
module dbnc_irq_chk
  import dbi_pkg::*;
#(
  parameter int NL = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                irq,
  input logic                clk_run,
  input logic [NL-1:0]       pend,
  input logic [NL-1:0]       levels,
  input logic [NL*CNT_W-1:0] cnt_flat
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pend == '0 && levels == '0 && !irq))
    else $error("reset state not quiet");

  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend != '0))
    else $error("irq without pending");

  assert_level_moves_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(levels) |-> $past(clk_run))
    else $error("level moved while idle");

  for (genvar g = 0; g < NL; g++) begin : g_chk
    assert_pend_on_level_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[g]) |-> !$stable(levels[g]))
      else $error("pending rose without level change");

    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[g*CNT_W +: CNT_W] < MS_MAX)
      else $error("counter beyond ceiling");
  end
endmodule

bind dbnc_irq_hub dbnc_irq_chk #(.NL(NL)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .clk_run  (clk_run),
  .pend     (pend_vec),
  .levels   (level_vec),
  .cnt_flat (cnt_flat)
);

// File: tb/dbnc_irq_hub_tb.sv
`timescale 1ns/1ps
module dbnc_irq_hub_tb;
  localparam int NL = 8;
  localparam int TDIV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ms_tick = 1'b0;
  logic [NL-1:0] line_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        irq, clk_run;

  int checks = 0;
  int errors = 0;
  int tdiv = 0;

  int m_s1[NL], m_s2[NL], m_st[NL], m_cnt[NL], m_pend[NL], m_lock[NL];
  int m_ms[NL], m_en[NL], m_tr[NL], m_os[NL];

  always #2 clk = ~clk;

  dbnc_irq_hub #(.NL(NL)) u_dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .line_in(line_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .clk_run(clk_run)
  );

  // Millisecond timebase
  always @(posedge clk) begin
    #1;
    if (tdiv == TDIV - 1) begin tdiv = 0; ms_tick = 1'b1; end
    else begin tdiv = tdiv + 1; ms_tick = 1'b0; end
  end

  // Behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_st[i] = 0; m_cnt[i] = 0; m_pend[i] = 0;
        m_lock[i] = 0; m_ms[i] = 0; m_en[i] = 0; m_tr[i] = 0; m_os[i] = 0;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin
        int lim;
        bit ev;
        lim = (m_ms[i] == 0) ? 1 : ((m_ms[i] > 4000) ? 4000 : m_ms[i]);
        ev = 0;
        if (m_s2[i] != m_st[i]) begin
          if (ms_tick) begin
            if (m_cnt[i] + 1 >= lim) begin
              m_st[i] = m_s2[i];
              m_cnt[i] = 0;
              if (m_s2[i] == m_tr[i] && !(m_os[i] != 0 && m_lock[i] != 0)) ev = 1;
            end else m_cnt[i] = m_cnt[i] + 1;
          end
        end else m_cnt[i] = 0;
        if (ev) m_pend[i] = 1;
        else if (wr_en && wr_addr == 4'd8 && wr_data[i]) m_pend[i] = 0;
        if (ev) m_lock[i] = 1;
        else if (wr_en && wr_addr == 4'd10 && wr_data[i]) m_lock[i] = 0;
        m_s2[i] = m_s1[i];
        m_s1[i] = int'(line_in[i]);
        if (wr_en && wr_addr == 4'(i)) begin
          m_ms[i] = int'(wr_data[11:0]);
          m_en[i] = int'(wr_data[12]);
          m_tr[i] = int'(wr_data[13]);
          m_os[i] = int'(wr_data[14]);
        end
      end
    end
  end

  // Per-cycle comparison of irq (R8) and clk_run (R9)
  always @(negedge clk) begin
    if (!rst) begin
      bit e_irq, e_run;
      e_irq = 0; e_run = 0;
      for (int i = 0; i < NL; i++) begin
        if (m_pend[i] != 0 && m_en[i] != 0) e_irq = 1;
        if (m_s2[i] != m_st[i]) e_run = 1;
      end
      checks = checks + 2;
      if (irq !== e_irq) begin
        errors++; $display("FAIL R8 irq act=%0d exp=%0d t=%0t", irq, e_irq, $time);
      end
      if (clk_run !== e_run) begin
        errors++; $display("FAIL R9 clk_run act=%0d exp=%0d t=%0t", clk_run, e_run, $time);
      end
    end
  end

  task automatic finish_up();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_up();
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd_bit(string tag, int a, int b, int exp);
    rd_addr = 4'(a);
    @(negedge clk);
    chk(tag, int'(rd_data[b]), exp);
    step();
  endtask

  task automatic rd_word(string tag, int a, int exp);
    rd_addr = 4'(a);
    @(negedge clk);
    chk(tag, int'(rd_data), exp);
    step();
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step();
    // R1: reset state
    rd_word("R1 pending", 8, 0);
    rd_word("R1 levels", 9, 0);
    rd_word("R1 locks", 10, 0);
    rd_word("R1 cfg0", 0, 0);
    @(negedge clk); chk("R1 irq", int'(irq), 0); chk("R1 clk_run", int'(clk_run), 0);
    step();

    wr(0, 16'h3003); wr(1, 16'h3005); wr(2, 16'h3000); wr(3, 16'h2FFF);
    wr(4, 16'h1002); wr(5, 16'h7001); wr(6, 16'h2001); wr(7, 16'h0005);

    // R2: 3 ms filter on line 0
    line_in[0] = 1'b1; step(60);
    rd_bit("R2 level0", 9, 0, 1);
    rd_bit("R2 pend0", 8, 0, 1);
    @(negedge clk); chk("R8 irq on", int'(irq), 1); step();

    // R7: write-1-to-clear, write 0 keeps
    wr(8, 16'h0000); rd_bit("R7 w0 keeps", 8, 0, 1);
    wr(8, 16'h0001); rd_bit("R7 cleared", 8, 0, 0);

    // R3: short excursion on 5 ms line
    line_in[1] = 1'b1; step(20); line_in[1] = 1'b0; step(100);
    rd_bit("R3 level1", 9, 1, 0);
    rd_bit("R3 pend1", 8, 1, 0);
    // R3: pulse with no tick inside
    do @(negedge clk); while (!ms_tick);
    step();
    line_in[2] = 1'b1; step(4); line_in[2] = 1'b0; step(40);
    rd_bit("R3 subms level2", 9, 2, 0);

    // R4: zero length acts as 1 ms
    line_in[2] = 1'b1; step(30);
    rd_bit("R4 zero len level2", 9, 2, 1);
    rd_bit("R4 zero len pend2", 8, 2, 1);
    wr(8, 16'h0004);

    // R5: trigger polarity 0 on line 4
    line_in[4] = 1'b1; step(50);
    rd_bit("R5 level4", 9, 4, 1);
    rd_bit("R5 no event on 1", 8, 4, 0);
    line_in[4] = 1'b0; step(50);
    rd_bit("R5 event on 0", 8, 4, 1);
    wr(8, 16'h0010);

    // R6: one-shot lock and re-arm on line 5
    line_in[5] = 1'b1; step(30);
    rd_bit("R6 first event", 8, 5, 1);
    rd_bit("R6 lock set", 10, 5, 1);
    wr(8, 16'h0020);
    line_in[5] = 1'b0; step(30); line_in[5] = 1'b1; step(30);
    rd_bit("R6 locked level", 9, 5, 1);
    rd_bit("R6 locked no event", 8, 5, 0);
    wr(10, 16'h0020);
    rd_bit("R6 rearmed", 10, 5, 0);
    line_in[5] = 1'b0; step(30); line_in[5] = 1'b1; step(30);
    rd_bit("R6 event after rearm", 8, 5, 1);
    wr(8, 16'h0020);

    // R8: masked pending, then enable
    line_in[6] = 1'b1; step(30);
    rd_bit("R8 pend6", 8, 6, 1);
    @(negedge clk); chk("R8 masked irq", int'(irq), 0); step();
    wr(6, 16'h3001);
    @(negedge clk); chk("R8 enabled irq", int'(irq), 1); step();
    wr(8, 16'h0040);
    @(negedge clk); chk("R8 cleared irq", int'(irq), 0); step();

    // R9: clk_run while line 7 filters
    line_in[7] = 1'b1; step(3);
    @(negedge clk); chk("R9 busy", int'(clk_run), 1); step(80);
    @(negedge clk); chk("R9 idle", int'(clk_run), 0); step();

    // R10: readback
    wr(7, 16'hFFFF); rd_word("R10 bit15 zero", 7, 16'h7FFF);
    wr(7, 16'h6ABC); rd_word("R10 readback", 7, 16'h6ABC);

    // R4: 4095 clamps to 4000 ms on line 3
    line_in[3] = 1'b1; step(3990 * TDIV);
    rd_bit("R4 before ceiling", 9, 3, 0);
    step(300);
    rd_bit("R4 at ceiling level", 9, 3, 1);
    rd_bit("R4 at ceiling pend", 8, 3, 1);

    step(5);
    finish_up();
  end
endmodule